// File: doc/BRIEF.md
# PLL Lock Status Qualifier

This block turns the raw lock flags of one transmit PLL and a parameterised number of receive PLLs into a single, debounced lock status. The status goes high only after every flag has been seen high without a break for a long qualify window. It goes low again only after at least one flag has been seen low without a break for a second, longer window. The different window lengths give the output hysteresis, so short dropouts of a PLL flag do not make the status toggle.

All timing is counted in cycles of the reference clock. The defaults are 49,250 cycles to assert and 131,625 cycles to drop, which is about 394 µs and 1053 µs at 125 MHz. A simulation can set both windows to a few cycles. Each raw flag passes through a two-flop synchronizer before the counter logic sees it.

An active-low external reset clears the status at once, with no clock edge needed. Because qualification restarts from zero after reset, the status then stays low for at least the assert window. The output is a plain active-high signal. Any open-collector wiring is left to the pad ring.

Top module: `pll_lock_qual`

## Requirements
- R1: While `rstN` is low, `lockOut` is 0 on every clock edge. With all flags low, `lockOut` stays 0.
- R2: With every synchronized flag high, `lockOut` rises exactly `ASSERT_CYCLES` edges after the synchronized AND first reads high. That is `ASSERT_CYCLES+2` edges after the raw flags change, and no earlier.
- R3: While `txLockRaw` is low, or any bit of `rxLockRaw` is low, `lockOut` never rises.
- R4: In the unlocked state, a single cycle in which any flag is low restarts the assert window from zero.
- R5: In the locked state, `lockOut` falls exactly `DEASSERT_CYCLES+2` edges after a raw flag goes low and stays low.
- R6: In the locked state, any cycle in which all flags read high again restarts the drop window from zero, and `lockOut` stays 1 meanwhile.
- R7: Driving `rstN` low forces `lockOut` to 0 without waiting for a clock edge.
- R8: After `rstN` is released with all flags already high, `lockOut` stays 0 for `ASSERT_CYCLES+1` edges and rises on edge `ASSERT_CYCLES+2`.
- R9: A flag change reaches the qualifier's decision only through two synchronizer stages. The synchronized AND equals the raw AND as it was two edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock that all qualify windows are counted in |
| rstN | input | 1 | Asynchronous active-low reset; clears the status and all counting |
| txLockRaw | input | 1 | Raw lock flag of the transmit PLL, asynchronous |
| rxLockRaw | input | NUM_RX | Raw lock flags of the receive PLLs, asynchronous |
| lockOut | output | 1 | Qualified lock status, active high |

## Verification
The bench targets the restart behaviour in both states. In the unlocked state it injects a one-cycle dropout partway through the assert window. A design that only paused its counter would then raise the status several cycles early. In the locked state it injects a one-cycle return to all-high while the drop window is running; a design without the restart would let the status fall too soon. The bench also probes the exact rise and fall edges, counting the two synchronizer stages, so an off-by-one terminal count is caught. It checks that asserting reset clears the status between clock edges, and that a release with flags already high still waits out the full assert window.

// File: rtl/lockq_pkg.sv
package lockq_pkg;

  typedef enum logic {
    ST_UNLOCKED = 1'b0,
    ST_LOCKED   = 1'b1
  } lockState_t;

  // strobes from the control FSM to the counting datapath
  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } cntStrobe_t;

endpackage

// File: rtl/lockq_sync.sv
module lockq_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= dIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stageQ[s] <= '0;
          else       stageQ[s] <= stageQ[s-1];
        end
      end
    end
  endgenerate

  assign dOut = stageQ[STAGES-1];

endmodule

// File: rtl/lockq_datapath.sv
module lockq_datapath
  import lockq_pkg::*;
#(
  parameter int NUM_RX          = 2,
  parameter int ASSERT_CYCLES   = 49250,
  parameter int DEASSERT_CYCLES = 131625,
  parameter int CNT_W           = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txLockRaw,
  input  logic [NUM_RX-1:0] rxLockRaw,
  input  cntStrobe_t        strobe,
  output logic              allHigh,
  output logic              atAssert,
  output logic              atDeassert,
  output logic [CNT_W-1:0]  cnt
);

  localparam int FLAGS = NUM_RX + 1;

  logic [FLAGS-1:0] rawFlags;
  logic [FLAGS-1:0] syncFlags;
  logic             rawAll;

  assign rawFlags = {txLockRaw, rxLockRaw};
  assign rawAll   = &rawFlags;

  lockq_sync #(
    .WIDTH  (FLAGS),
    .STAGES (2)
  ) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .dIn  (rawFlags),
    .dOut (syncFlags)
  );

  assign allHigh = &syncFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.cntClear) cnt <= '0;
    else if (strobe.cntInc)   cnt <= cnt + 1'b1;
  end

  assign atAssert   = (cnt == CNT_W'(ASSERT_CYCLES - 1));
  assign atDeassert = (cnt == CNT_W'(DEASSERT_CYCLES - 1));

  // R9: synchronized AND follows the raw AND two edges later
  a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(allHigh) |-> (allHigh == $past(rawAll, 2)));

endmodule

// File: rtl/lockq_ctrl.sv
module lockq_ctrl
  import lockq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       allHigh,
  input  logic       atAssert,
  input  logic       atDeassert,
  output cntStrobe_t strobe,
  output logic       lockOut
);

  lockState_t state, stateNext;

  always_comb begin
    stateNext       = state;
    strobe.cntClear = 1'b0;
    strobe.cntInc   = 1'b0;
    unique case (state)
      ST_UNLOCKED: begin
        if (!allHigh) begin
          strobe.cntClear = 1'b1;
        end else if (atAssert) begin
          strobe.cntClear = 1'b1;
          stateNext       = ST_LOCKED;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_LOCKED: begin
        if (allHigh) begin
          strobe.cntClear = 1'b1;
        end else if (atDeassert) begin
          strobe.cntClear = 1'b1;
          stateNext       = ST_UNLOCKED;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      default: stateNext = ST_UNLOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_UNLOCKED;
    else       state <= stateNext;
  end

  assign lockOut = (state == ST_LOCKED);

  // R2: a rise is only ever preceded by an all-high synchronized sample
  a_r2_rise_needs_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockOut) |-> $past(allHigh));

  // R5: a fall outside reset is only ever preceded by a low sample
  a_r5_fall_needs_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockOut) |-> !$past(allHigh));

endmodule

// File: rtl/pll_lock_qual.sv
module pll_lock_qual
  import lockq_pkg::*;
#(
  parameter int NUM_RX          = 2,
  parameter int ASSERT_CYCLES   = 49250,
  parameter int DEASSERT_CYCLES = 131625
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txLockRaw,
  input  logic [NUM_RX-1:0] rxLockRaw,
  output logic              lockOut
);

  localparam int MAX_CYCLES = (ASSERT_CYCLES > DEASSERT_CYCLES) ? ASSERT_CYCLES : DEASSERT_CYCLES;
  localparam int CNT_W      = $clog2(MAX_CYCLES + 1);

  cntStrobe_t       strobe;
  logic             allHigh;
  logic             atAssert;
  logic             atDeassert;
  logic [CNT_W-1:0] cnt;

  lockq_datapath #(
    .NUM_RX          (NUM_RX),
    .ASSERT_CYCLES   (ASSERT_CYCLES),
    .DEASSERT_CYCLES (DEASSERT_CYCLES),
    .CNT_W           (CNT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .txLockRaw  (txLockRaw),
    .rxLockRaw  (rxLockRaw),
    .strobe     (strobe),
    .allHigh    (allHigh),
    .atAssert   (atAssert),
    .atDeassert (atDeassert),
    .cnt        (cnt)
  );

  lockq_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .allHigh    (allHigh),
    .atAssert   (atAssert),
    .atDeassert (atDeassert),
    .strobe     (strobe),
    .lockOut    (lockOut)
  );

  // R1 / R7: reset holds the status low
  a_r1_reset_low: assert property (@(posedge clk)
    !rstN |-> !lockOut);

  // R4: a low sample while unlocked restarts the assert window
  a_r4_glitch_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (!lockOut && !allHigh) |=> (cnt == '0));

  // R6: an all-high sample while locked restarts the drop window
  a_r6_recover_restarts: assert property (@(posedge clk) disable iff (!rstN)
    (lockOut && allHigh) |=> (cnt == '0));

  // R3: counting while unlocked never passes the assert window
  a_r3_unlocked_bound: assert property (@(posedge clk) disable iff (!rstN)
    !lockOut |-> (cnt < CNT_W'(ASSERT_CYCLES)));

endmodule

// File: tb/test_pll_lock_qual.sv
module test_pll_lock_qual;

  localparam int A = 12;
  localparam int D = 20;
  localparam int NRX = 2;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic txLockRaw = 1'b0;
  logic [NRX-1:0] rxLockRaw = '0;
  logic lockOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pll_lock_qual #(
    .NUM_RX          (NRX),
    .ASSERT_CYCLES   (A),
    .DEASSERT_CYCLES (D)
  ) i_pll_lock_qual (
    .clk       (clk),
    .rstN      (rstN),
    .txLockRaw (txLockRaw),
    .rxLockRaw (rxLockRaw),
    .lockOut   (lockOut)
  );

  // entry: {flags[2:0] = {tx, rx1, rx0}, edges[7:0], expected lock, requirement number[3:0]}
  localparam logic [15:0] VEC [17] = '{
    {3'b000, 8'd5,  1'b0, 4'd1},  // R1 idle after reset
    {3'b110, 8'd30, 1'b0, 4'd3},  // R3 one receive flag low
    {3'b011, 8'd30, 1'b0, 4'd3},  // R3 transmit flag low
    {3'b111, 8'd13, 1'b0, 4'd2},  // R2 one edge before the rise
    {3'b111, 8'd1,  1'b1, 4'd2},  // R2 rise on edge A+2
    {3'b101, 8'd21, 1'b1, 4'd5},  // R5 still high one edge early
    {3'b101, 8'd1,  1'b0, 4'd5},  // R5 fall on edge D+2
    {3'b111, 8'd6,  1'b0, 4'd4},  // R4 partial window
    {3'b011, 8'd1,  1'b0, 4'd4},  // R4 one-cycle dropout
    {3'b111, 8'd12, 1'b0, 4'd4},  // R4 unrestarted count would be high here
    {3'b111, 8'd1,  1'b0, 4'd4},  // R4 still low
    {3'b111, 8'd1,  1'b1, 4'd4},  // R4 rise after the restarted window
    {3'b110, 8'd10, 1'b1, 4'd6},  // R6 partial drop window
    {3'b111, 8'd1,  1'b1, 4'd6},  // R6 one-cycle return to all-high
    {3'b110, 8'd15, 1'b1, 4'd6},  // R6 unrestarted count would be low here
    {3'b110, 8'd6,  1'b1, 4'd6},  // R6 one edge before the restarted fall
    {3'b110, 8'd1,  1'b0, 4'd6}   // R6 fall after the restarted window
  };

  task automatic check(input logic exp, input int req, input string what);
    checks++;
    if (lockOut !== exp) begin
      errors++;
      $display("FAIL R%0d %s: lockOut=%b expected=%b", req, what, lockOut, exp);
    end
  endtask

  task automatic run(input logic [2:0] f, input int n);
    {txLockRaw, rxLockRaw} = f;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1'b0, 1, "in reset");  // R1
    rstN = 1'b1;

    for (int i = 0; i < 17; i++) begin
      run(VEC[i][15:13], int'(VEC[i][12:5]));
      check(VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R2: relock before the reset tests
    run(3'b111, A + 2);
    check(1'b1, 2, "relock");

    // R7: reset clears the status between edges
    #1 rstN = 1'b0;
    #0.5;
    check(1'b0, 7, "async clear");
    @(negedge clk);
    check(1'b0, 1, "held in reset");

    // R8: release with flags already high
    rstN = 1'b1;
    repeat (A + 1) @(posedge clk);
    @(negedge clk);
    check(1'b0, 8, "low after A+1 edges");
    repeat (1) @(posedge clk);
    @(negedge clk);
    check(1'b1, 8, "rise on edge A+2");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: lockOut=%b expected=finished", lockOut);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule